// File: doc/BRIEF.md
# Register-Reference Accumulator Unit

This unit carries out the register-reference operations of a small accumulator machine. The sequencer hands it the twelve low operation bits of an instruction whose opcode field is 7 with the mode bit clear, together with a valid strobe and the present 16-bit accumulator and the 1-bit extension flag E. One clock later the unit presents the new accumulator and extension values and a one-cycle done pulse. Along with done it may raise a skip request, which tells the sequencer to advance the program counter one extra word.

Each operation is picked by a single bit of the operation field. If several bits are set together, only the highest-numbered set bit acts. A halt operation sets a halt output that stays set until reset. While halt is set the unit accepts no further operations.

Top module: `regref_acc_unit`

## Requirements
- R1: While rst_n is low and in the first cycle after it, acc_q, ext_q, skip_req, halted and done are all 0.
- R2: An operation taken while op_valid is high and halted is low raises done for exactly the next cycle. In a cycle with op_valid low, done falls and acc_q and ext_q hold their values.
- R3: Bit 11 clears the accumulator, bit 9 inverts every accumulator bit, and bit 5 adds one modulo 2^16 with the carry dropped. All three leave E unchanged.
- R4: Bit 10 clears E and bit 8 complements E. Both leave the accumulator unchanged.
- R5: Bit 7 rotates right through E: new acc[14:0] = acc[15:1], new acc[15] = E, new E = acc[0].
- R6: Bit 6 rotates left through E: new acc[15:1] = acc[14:0], new acc[0] = E, new E = acc[15].
- R7: These bits raise skip_req together with done: bit 4 when acc[15] is 0 and acc is non-zero, bit 3 when acc[15] is 1, bit 2 when acc is zero, and bit 1 when E is 0. In every other case skip_req is 0. Skip operations pass the accumulator and E through unchanged.
- R8: Bit 0 sets halted together with done and passes the accumulator and E through. From then on halted stays high until reset, later strobes produce no done, and acc_q and ext_q keep their values.
- R9: When several operation bits are set, only the highest-numbered one takes effect.
- R10: A strobe with all twelve operation bits clear still gives done, copies the inputs to the outputs, and raises no skip or halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe for this cycle |
| op_bits | input | 12 | Operation field, one bit per operation |
| acc_in | input | 16 | Present accumulator value |
| ext_in | input | 1 | Present extension flag E |
| acc_q | output | 16 | Resulting accumulator |
| ext_q | output | 1 | Resulting extension flag |
| skip_req | output | 1 | Request for one extra program-counter step |
| halted | output | 1 | Sticky halt indication |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can meet in one strobe when several operation bits are set at once. One case is a register update together with a skip test or a halt. Another is two updates that would undo each other, such as clear and complement. The bench drives such mixed fields, for example clear with complement, a skip test with halt, and complement-E with rotate. It checks that the result is exactly what the highest-numbered bit alone would give: no skip or halt from a lower bit, and no trace of the lower update on the accumulator or E.

// File: rtl/rr_pkg.sv
package rr_pkg;
    parameter int AC_W = 16;
    parameter int OP_W = 12;

    // Operation bit positions; the sequencer encodes these, and a higher
    // index has priority over a lower one.
    localparam int B_CLR_AC  = 11;
    localparam int B_CLR_E   = 10;
    localparam int B_INV_AC  = 9;
    localparam int B_INV_E   = 8;
    localparam int B_ROT_R   = 7;
    localparam int B_ROT_L   = 6;
    localparam int B_INCR    = 5;
    localparam int B_SK_POS  = 4;
    localparam int B_SK_NEG  = 3;
    localparam int B_SK_ZAC  = 2;
    localparam int B_SK_ZE   = 1;
    localparam int B_STOP    = 0;

    typedef struct packed {
        logic [AC_W-1:0] acc;
        logic            ext;
        logic            skip;
        logic            halt;
        logic            done;
    } rr_state_t;
endpackage

// File: rtl/rr_prio_pick.sv
module rr_prio_pick #(
    parameter int N = 12
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    // Highest index wins: a bit is granted only if no bit above it is set.
    for (genvar i = 0; i < N; i++) begin : g_lane
        if (i == N - 1) begin : g_top
            assign grant[i] = req[i];
        end else begin : g_low
            assign grant[i] = req[i] & ~(|req[N-1:i+1]);
        end
    end
endmodule

// File: rtl/rr_ac_datapath.sv
module rr_ac_datapath
    import rr_pkg::*;
(
    input  logic [OP_W-1:0] grant,
    input  logic [AC_W-1:0] acc,
    input  logic            ext,
    output logic [AC_W-1:0] acc_nx,
    output logic            ext_nx
);
    localparam logic [AC_W-1:0] ONE = AC_W'(1);

    always_comb begin
        acc_nx = acc;
        ext_nx = ext;
        if (grant[B_CLR_AC]) begin
            acc_nx = '0;
        end else if (grant[B_CLR_E]) begin
            ext_nx = 1'b0;
        end else if (grant[B_INV_AC]) begin
            acc_nx = ~acc;
        end else if (grant[B_INV_E]) begin
            ext_nx = ~ext;
        end else if (grant[B_ROT_R]) begin
            acc_nx = {ext, acc[AC_W-1:1]};
            ext_nx = acc[0];
        end else if (grant[B_ROT_L]) begin
            acc_nx = {acc[AC_W-2:0], ext};
            ext_nx = acc[AC_W-1];
        end else if (grant[B_INCR]) begin
            acc_nx = acc + ONE;
        end
    end
endmodule

// File: rtl/rr_skip_eval.sv
module rr_skip_eval
    import rr_pkg::*;
(
    input  logic [OP_W-1:0] grant,
    input  logic [AC_W-1:0] acc,
    input  logic            ext,
    output logic            skip_hit
);
    logic acc_zero;
    logic acc_sign;

    always_comb begin
        acc_zero = (acc == '0);
        acc_sign = acc[AC_W-1];
        skip_hit = (grant[B_SK_POS] & ~acc_sign & ~acc_zero)
                 | (grant[B_SK_NEG] &  acc_sign)
                 | (grant[B_SK_ZAC] &  acc_zero)
                 | (grant[B_SK_ZE]  & ~ext);
    end
endmodule

// File: rtl/regref_acc_unit.sv
module regref_acc_unit
    import rr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [11:0]     op_bits,
    input  logic [15:0]     acc_in,
    input  logic            ext_in,
    output logic [15:0]     acc_q,
    output logic            ext_q,
    output logic            skip_req,
    output logic            halted,
    output logic            done
);
    rr_state_t       st_d;
    rr_state_t       st_q;
    logic [OP_W-1:0] grant;
    logic [AC_W-1:0] acc_nx;
    logic            ext_nx;
    logic            skip_hit;
    logic            take;

    rr_prio_pick #(.N(OP_W)) u_pick (
        .req   (op_bits),
        .grant (grant)
    );

    rr_ac_datapath u_dp (
        .grant  (grant),
        .acc    (acc_in),
        .ext    (ext_in),
        .acc_nx (acc_nx),
        .ext_nx (ext_nx)
    );

    rr_skip_eval u_sk (
        .grant    (grant),
        .acc      (acc_in),
        .ext      (ext_in),
        .skip_hit (skip_hit)
    );

    assign take = op_valid & ~st_q.halt;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.skip = 1'b0;
        if (take) begin
            st_d.acc  = acc_nx;
            st_d.ext  = ext_nx;
            st_d.skip = skip_hit;
            st_d.done = 1'b1;
            if (grant[B_STOP]) begin
                st_d.halt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_q    = st_q.acc;
    assign ext_q    = st_q.ext;
    assign skip_req = st_q.skip;
    assign halted   = st_q.halt;
    assign done     = st_q.done;
endmodule

// File: rtl/rr_acc_checks.sv
module rr_acc_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [11:0] op_bits,
    input logic [15:0] acc_in,
    input logic        ext_in,
    input logic [15:0] acc_q,
    input logic        ext_q,
    input logic        skip_req,
    input logic        halted,
    input logic        done
);
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !halted |=> done);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !done && $stable(acc_q) && $stable(ext_q));

    p_clear_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !halted && op_bits[11] |=> acc_q == 16'h0000);

    p_flip_e_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !halted && op_bits[11:8] == 4'b0001 |=> ext_q != $past(ext_in));

    p_rot_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !halted && op_bits[11:7] == 5'b00001
        |=> acc_q == {$past(ext_in), $past(acc_in[15:1])} && ext_q == $past(acc_in[0]));

    p_skip_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> done);

    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && !done && $stable(acc_q));

    p_top_bit_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !halted && op_bits[11] && op_bits[0] |=> !halted);
endmodule

bind regref_acc_unit rr_acc_checks u_chk (.*);

// File: tb/sim_regref_acc_unit.sv
module sim_regref_acc_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [11:0] op_bits;
    logic [15:0] acc_in;
    logic        ext_in;
    logic [15:0] acc_q;
    logic        ext_q;
    logic        skip_req;
    logic        halted;
    logic        done;

    typedef struct {
        logic [15:0] acc;
        logic        ext;
        logic        skip;
        logic        halt;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    regref_acc_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_bits(op_bits),
        .acc_in(acc_in), .ext_in(ext_in), .acc_q(acc_q), .ext_q(ext_q),
        .skip_req(skip_req), .halted(halted), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [11:0] b, input logic [15:0] a,
                                   input logic e, input string tag);
        exp_t r;
        int   sel = -1;
        r.acc = a; r.ext = e; r.skip = 1'b0; r.halt = 1'b0; r.tag = tag;
        for (int i = 11; i >= 0; i--) begin
            if (b[i] && sel < 0) sel = i;
        end
        case (sel)
            11: r.acc = 16'h0000;
            10: r.ext = 1'b0;
            9:  r.acc = ~a;
            8:  r.ext = ~e;
            7:  begin r.acc = {e, a[15:1]}; r.ext = a[0]; end
            6:  begin r.acc = {a[14:0], e}; r.ext = a[15]; end
            5:  r.acc = a + 16'h0001;
            4:  r.skip = !a[15] && (a != 16'h0000);
            3:  r.skip = a[15];
            2:  r.skip = (a == 16'h0000);
            1:  r.skip = !e;
            0:  r.halt = 1'b1;
            default: ;
        endcase
        return r;
    endfunction

    task automatic send(input logic [11:0] b, input logic [15:0] a,
                        input logic e, input string tag);
        @(negedge clk);
        op_valid = 1'b1; op_bits = b; acc_in = a; ext_in = e;
        exp_q.push_back(model(b, a, e, tag));
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // Monitor: compares each completion against the oldest expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected done", 32'(done), 32'h0);
                end else begin
                    exp_t x;
                    x = exp_q.pop_front();
                    chk(acc_q == x.acc, x.tag, "acc", 32'(acc_q), 32'(x.acc));
                    chk(ext_q == x.ext, x.tag, "ext", 32'(ext_q), 32'(x.ext));
                    chk(skip_req == x.skip, x.tag, "skip", 32'(skip_req), 32'(x.skip));
                    chk(halted == x.halt, x.tag, "halt", 32'(halted), 32'(x.halt));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_bits = '0; acc_in = '0; ext_in = 1'b0;
        repeat (3) @(negedge clk);
        chk({acc_q, ext_q, skip_req, halted, done} == '0, "R1", "reset state",
            32'({acc_q, ext_q, skip_req, halted, done}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({acc_q, ext_q, skip_req, halted, done} == '0, "R1", "after reset",
            32'({acc_q, ext_q, skip_req, halted, done}), 32'h0);

        // R3 accumulator clear, invert, increment
        send(12'h800, 16'h1234, 1'b1, "R3");
        send(12'h200, 16'h00F0, 1'b0, "R3");
        send(12'h020, 16'hFFFF, 1'b1, "R3");
        send(12'h020, 16'h7FFF, 1'b0, "R3");
        // R2: idle cycle holds outputs and keeps done low
        @(negedge clk);
        chk(!done && acc_q == 16'h8000, "R2", "idle hold", 32'({done, acc_q}), 32'h8000);
        // R4 E clear, complement
        send(12'h400, 16'hABCD, 1'b1, "R4");
        send(12'h100, 16'hABCD, 1'b0, "R4");
        // R5 rotate right through E
        send(12'h080, 16'h0001, 1'b1, "R5");
        send(12'h080, 16'h8002, 1'b0, "R5");
        // R6 rotate left through E
        send(12'h040, 16'h8000, 1'b0, "R6");
        send(12'h040, 16'h4001, 1'b1, "R6");
        // R7 skip tests
        send(12'h010, 16'h0005, 1'b0, "R7");
        send(12'h010, 16'h0000, 1'b0, "R7");
        send(12'h010, 16'h8000, 1'b0, "R7");
        send(12'h008, 16'h8000, 1'b1, "R7");
        send(12'h008, 16'h0001, 1'b1, "R7");
        send(12'h004, 16'h0000, 1'b1, "R7");
        send(12'h004, 16'h0100, 1'b1, "R7");
        send(12'h002, 16'h0042, 1'b0, "R7");
        send(12'h002, 16'h0042, 1'b1, "R7");
        // R9 mixed fields: highest bit alone acts
        send(12'hA00, 16'h5A5A, 1'b1, "R9");
        send(12'h011, 16'h0005, 1'b0, "R9");
        send(12'h180, 16'h0003, 1'b0, "R9");
        send(12'h00C, 16'h0000, 1'b1, "R9");
        // R10 empty field
        send(12'h000, 16'hC3C3, 1'b1, "R10");
        // R8 halt, then an ignored strobe
        send(12'h001, 16'h1111, 1'b0, "R8");
        @(negedge clk);
        op_valid = 1'b1; op_bits = 12'h800; acc_in = 16'h0005; ext_in = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        chk(!done, "R8", "done after halt", 32'(done), 32'h0);
        chk(acc_q == 16'h1111 && ext_q == 1'b0, "R8", "frozen state",
            32'({acc_q, ext_q}), 32'({16'h1111, 1'b0}));
        chk(halted, "R8", "halt sticky", 32'(halted), 32'h1);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "pending results", 32'(exp_q.size()), 32'h0);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule